// File: doc/BRIEF.md
# Latency-Tolerant Core Wrapper

This block wraps a small synchronous core so that the core produces the same result stream whatever delay its channels have. Each input channel presents a data word with a valid flag and receives a stop flag back. Each channel has its own input FIFO. The single output channel presents a data word with a valid flag and receives a stop flag from downstream. The core here is a running-sum accumulator. It stands in for real logic and is frozen through a register enable, never through its clock. On each advance it takes exactly one word from every input FIFO and emits one result.

The parameter `REG_EN` selects how the enable is produced. In the direct form the enable is a combinational function of FIFO occupancy and the output stop. In the registered form the enable is a flop computed one cycle ahead from local occupancy only, and input stop is registered as well. This keeps external valid and stop wires out of the enable fan-out cone. The cost is one cycle of extra latency and a three-entry output buffer.

Top module: `li_wrapper`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `in_stop` is 0.
- R2: The core advances only when every input FIFO holds a word. Each advance removes one word from every FIFO. The k-th output word equals the sum, modulo 2^WIDTH, of all words consumed in advances 1 to k. Channel i occupies bits `[i*WIDTH +: WIDTH]` of `in_data`.
- R3: No input FIFO ever overflows. With `REG_EN=0`, `in_stop[i]` is high exactly while FIFO i holds DEPTH words. With `REG_EN=1`, `in_stop[i]` is a register that is high in the cycle after FIFO i held at least DEPTH-1 words.
- R4: A word offered with `in_valid[i]` high while `in_stop[i]` is high is dropped and never reaches the output stream.
- R5: While `out_valid` and `out_stop` are both high, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R6: The core does not advance when the output buffer is full and is not draining in that cycle. With `REG_EN=0` the buffer has one entry. With `out_stop` held high from an empty state and inputs valid on every cycle, each channel therefore accepts exactly DEPTH+1 words.
- R7: Under any pattern of input gaps and output stops, the output stream matches the reference sum sequence in order, with no lost and no repeated words. After draining, the number of outputs equals the smallest per-channel count of accepted words.
- R8: From the clock edge that captures one word on every channel into an idle wrapper with `out_stop` low, `out_valid` rises one edge later when `REG_EN=0` and two edges later when `REG_EN=1`.
- R9: With every input valid on each cycle and `out_stop` low, both modes deliver one output word per cycle in steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | NUM_IN*WIDTH | Input words, channel i in slice i |
| in_valid | input | NUM_IN | Word present per channel |
| in_stop | output | NUM_IN | Backpressure per channel toward the sender |
| out_data | output | WIDTH | Result word |
| out_valid | output | 1 | Result present |
| out_stop | input | 1 | Backpressure from the receiver |

## Verification
The bench builds two copies side by side, both with two 16-bit channels and four-entry input FIFOs. One uses `REG_EN=0` and the other `REG_EN=1`, so the one-cycle latency gap and the difference between the exact full-based stop and the early registered stop are both measured directly. The four-entry depth lets the registered mode still sustain full rate with one spare slot. The same depth also makes the blocked-output fill count small enough to predict exactly for the direct mode.

// File: rtl/li_wrapper.sv
module li_wrapper #(
  parameter int NUM_IN = 2,
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 4,
  parameter bit REG_EN = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IN*WIDTH-1:0] in_data,
  input  logic [NUM_IN-1:0]       in_valid,
  output logic [NUM_IN-1:0]       in_stop,
  output logic [WIDTH-1:0]        out_data,
  output logic                    out_valid,
  input  logic                    out_stop
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int OD  = REG_EN ? 3 : 1;
  localparam int OCW = 3;

  logic              fire, opop, oq_full;
  logic [NUM_IN-1:0] push, full, has_data;
  logic [CW-1:0]     cnt  [NUM_IN];
  logic [WIDTH-1:0]  head [NUM_IN];
  logic [WIDTH-1:0]  acc, sum;
  logic [WIDTH-1:0]  oq [4];
  logic [1:0]        orp, owp;
  logic [OCW-1:0]    ocnt;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rp, wp;
    logic [CW-1:0]    n;

    assign cnt[i]      = n;
    assign full[i]     = n == CW'(DEPTH);
    assign has_data[i] = n != '0;
    assign push[i]     = in_valid[i] & ~in_stop[i];
    assign head[i]     = mem[rp];

    always_ff @(posedge clk)
      if (push[i]) mem[wp] <= in_data[i*WIDTH +: WIDTH];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rp <= '0;
        wp <= '0;
        n  <= '0;
      end else begin
        if (push[i]) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
        if (fire)    rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        n <= n + CW'(push[i]) - CW'(fire);
      end

    if (REG_EN) begin : g_stop_reg
      logic s;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s <= 1'b0;
        else        s <= n >= CW'(DEPTH - 1);
      assign in_stop[i] = s;
    end else begin : g_stop_dir
      assign in_stop[i] = full[i];
    end
  end

  always_comb begin
    sum = acc;
    for (int i = 0; i < NUM_IN; i++) sum = sum + head[i];
  end

  assign oq_full   = ocnt == OCW'(OD);
  assign out_valid = ocnt != '0;
  assign out_data  = oq[orp];
  assign opop      = out_valid & ~out_stop;

  if (REG_EN) begin : g_en_reg
    logic en_q, go;
    always_comb begin
      go = (ocnt + OCW'(fire)) <= OCW'(OD - 1);
      for (int i = 0; i < NUM_IN; i++)
        if (cnt[i] <= CW'(fire)) go = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= go;
    assign fire = en_q;
  end else begin : g_en_dir
    assign fire = (&has_data) & (~oq_full | opop);
  end

  always_ff @(posedge clk)
    if (fire) oq[owp] <= sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc  <= '0;
      orp  <= '0;
      owp  <= '0;
      ocnt <= '0;
    end else begin
      if (fire) begin
        acc <= sum;
        owp <= (owp == 2'(OD - 1)) ? 2'd0 : owp + 2'd1;
      end
      if (opop) orp <= (orp == 2'(OD - 1)) ? 2'd0 : orp + 2'd1;
      ocnt <= ocnt + OCW'(fire) - OCW'(opop);
    end
endmodule

// File: rtl/li_wrapper_chk.sv
module li_wrapper_chk #(
  parameter int NUM_IN = 2,
  parameter int WIDTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              opop,
  input logic              oq_full,
  input logic [NUM_IN-1:0] push,
  input logic [NUM_IN-1:0] full,
  input logic [NUM_IN-1:0] has_data,
  input logic              out_valid,
  input logic              out_stop,
  input logic [WIDTH-1:0]  out_data
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push & full) == '0); // R3

  AST_ALL_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> &has_data); // R2

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stop |=> out_valid && $stable(out_data)); // R5

  AST_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    fire && oq_full |-> opop); // R6
endmodule

bind li_wrapper li_wrapper_chk #(.NUM_IN(NUM_IN), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .opop(opop), .oq_full(oq_full),
  .push(push), .full(full), .has_data(has_data),
  .out_valid(out_valid), .out_stop(out_stop), .out_data(out_data));

// File: tb/sim_li_wrapper.sv
module sim_li_wrapper;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 2;
  localparam int W  = 16;
  localparam int D  = 4;
  localparam int CAP = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI*W-1:0] dat   [2];
  logic [NI-1:0]   vld   [2];
  logic [NI-1:0]   istop [2];
  logic [W-1:0]    od    [2];
  logic            ov    [2];
  logic            ostop [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  li_wrapper #(.NUM_IN(NI), .WIDTH(W), .DEPTH(D), .REG_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(dat[0]), .in_valid(vld[0]), .in_stop(istop[0]),
    .out_data(od[0]), .out_valid(ov[0]), .out_stop(ostop[0]));

  li_wrapper #(.NUM_IN(NI), .WIDTH(W), .DEPTH(D), .REG_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_data(dat[1]), .in_valid(vld[1]), .in_stop(istop[1]),
    .out_data(od[1]), .out_valid(ov[1]), .out_stop(ostop[1]));

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int vld_pct = 0;
  int stop_pct = 0;

  logic [W-1:0] sent [2][NI][CAP];
  int           nsent [2][NI];
  int           acc_cnt [2][NI];
  int           nout [2];
  int           xfer [2];
  logic [W-1:0] racc [2];
  bit           prev_hold [2];
  logic [W-1:0] prev_data [2];

  task automatic fail(input string msg);
    nerr++;
    $display("FAIL %s", msg);
  endtask

  task automatic check(input bit ok, input string msg);
    nchk++;
    if (!ok) fail(msg);
  endtask

  task automatic cycle();
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      if (prev_hold[d]) begin
        nchk++;
        if (!ov[d] || od[d] !== prev_data[d])
          fail($sformatf("R5 dut%0d held output: got v=%0b %h expected v=1 %h",
                         d, ov[d], od[d], prev_data[d]));
      end
      ostop[d] = ($urandom % 100) < stop_pct;
      if (ov[d] && !ostop[d]) begin
        int k;
        bit ok;
        logic [W-1:0] e;
        k = nout[d];
        ok = 1'b1;
        e = racc[d];
        for (int i = 0; i < NI; i++)
          if (nsent[d][i] <= k) ok = 1'b0;
          else e = e + sent[d][i][k];
        nchk++;
        if (!ok || od[d] !== e)
          fail($sformatf("R2/R7 dut%0d word %0d: got %h expected %h (inputs present %0b)",
                         d, k, od[d], e, ok));
        racc[d] = e;
        nout[d]++;
        xfer[d]++;
      end
      prev_hold[d] = ov[d] && ostop[d];
      prev_data[d] = od[d];
      for (int i = 0; i < NI; i++) begin
        bit v;
        logic [W-1:0] w;
        v = ($urandom % 100) < vld_pct;
        w = W'($urandom);
        vld[d][i] = v;
        dat[d][i*W +: W] = w;
        if (v && !istop[d][i] && rst_n) begin
          if (nsent[d][i] < CAP) sent[d][i][nsent[d][i]] = w;
          nsent[d][i]++;
          acc_cnt[d][i]++;
        end
      end
    end
  endtask

  task automatic run(input int n, input int vp, input int sp);
    vld_pct = vp;
    stop_pct = sp;
    for (int c = 0; c < n; c++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int lat [2];
    for (int d = 0; d < 2; d++) begin
      vld[d] = '0;
      dat[d] = '0;
      ostop[d] = 1'b0;
      nout[d] = 0;
      xfer[d] = 0;
      racc[d] = '0;
      prev_hold[d] = 1'b0;
      prev_data[d] = '0;
      for (int i = 0; i < NI; i++) begin
        nsent[d][i] = 0;
        acc_cnt[d][i] = 0;
      end
    end
    run(4, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      check(ov[d] == 1'b0 && istop[d] == '0,
            $sformatf("R1 dut%0d reset state: got v=%0b stop=%b expected v=0 stop=0",
                      d, ov[d], istop[d]));

    run(1, 100, 0);
    vld_pct = 0;
    lat[0] = -1;
    lat[1] = -1;
    for (int j = 1; j <= 6; j++) begin
      cycle();
      for (int d = 0; d < 2; d++)
        if (lat[d] < 0 && ov[d]) lat[d] = j;
    end
    check(lat[0] == 2, $sformatf("R8 direct latency: got %0d expected 2", lat[0]));
    check(lat[1] == 3, $sformatf("R8 registered latency: got %0d expected 3", lat[1]));

    run(10, 100, 0);
    xfer[0] = 0;
    xfer[1] = 0;
    run(20, 100, 0);
    for (int d = 0; d < 2; d++)
      check(xfer[d] == 20, $sformatf("R9 dut%0d steady rate: got %0d expected 20", d, xfer[d]));

    run(20, 0, 0);
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < NI; i++) acc_cnt[d][i] = 0;
    run(30, 100, 100);
    for (int i = 0; i < NI; i++)
      check(acc_cnt[0][i] == D + 1,
            $sformatf("R6/R4 direct ch%0d accepted while blocked: got %0d expected %0d",
                      i, acc_cnt[0][i], D + 1));
    for (int d = 0; d < 2; d++) begin
      check(istop[d] == '1, $sformatf("R3 dut%0d stop while blocked: got %b expected all ones",
                                      d, istop[d]));
      check(ov[d] == 1'b1, $sformatf("R5 dut%0d valid while blocked: got %0b expected 1",
                                     d, ov[d]));
    end
    run(25, 0, 0);

    run(1500, 70, 30);
    run(40, 0, 0);

    for (int d = 0; d < 2; d++) begin
      int m;
      m = nsent[d][0];
      for (int i = 1; i < NI; i++) if (nsent[d][i] < m) m = nsent[d][i];
      check(nout[d] == m, $sformatf("R7 dut%0d output count: got %0d expected %0d",
                                    d, nout[d], m));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule